// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Enable

This block derives the clock of a slower audio subsystem from a fast master clock. It does not divide the clock. It emits a one-cycle enable pulse at an average rate that equals an exact rational fraction of the master rate. An integer phase register adds a fixed step on every master clock. Each time the phase passes the modulus, the modulus is taken back out and one audio-cycle enable is produced. Because only integer arithmetic is used, the number of pulses after any number of clocks is exact, and no error builds up over a long run.

Two ratios share the step and differ only in the modulus. A one-bit mode input picks the modulus on every clock. Changing it does not disturb the phase already accumulated. A second enable marks one audio cycle in every 32 to pace a sample engine. It fires on the audio cycles whose running index is a multiple of 32, and the first audio cycle after reset is index zero.

Top module: `audio_clk_en_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, both `aud_en` and `smp_en` are 0. Reset clears the phase and the 32-cycle index, so in either mode the first `aud_en` after reset occurs on the ceil(MOD/STEP)-th rising edge after reset is released.
- R2: With `mode_sel` = 0 the modulus is 21,437,280 and the step is 1,025,280. After n clocks from reset, exactly floor(n·1,025,280 / 21,437,280) `aud_en` pulses have been produced.
- R3: With `mode_sel` = 1 the modulus is 21,268,800 and the step is the same. After n clocks from reset, exactly floor(n·1,025,280 / 21,268,800) pulses have been produced.
- R4: `aud_en` is never high on two consecutive clocks.
- R5: `smp_en` is high only on a clock where `aud_en` is also high.
- R6: `smp_en` marks the first `aud_en` after reset and then every 32nd `aud_en`. Exactly 32 audio pulses separate consecutive sample pulses.
- R7: A change of `mode_sel` applies to the accumulation on the same clock edge. The phase and the 32-cycle index are kept, so the output matches an integer model that switches its modulus on that edge.
- R8: Both outputs are registered. A pulse caused by the accumulation at edge k is visible from edge k to edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Ratio select: 0 picks the larger modulus, 1 the smaller |
| aud_en | output | 1 | One-clock audio-cycle enable |
| smp_en | output | 1 | One-clock enable on every 32nd audio cycle |

## Verification
The enables are compared clock by clock against an integer model under four input patterns:
- A long run in mode 0. Its pulse total over thousands of clocks exposes any rounding or drift.
- A run in mode 1. Its different pulse total shows that the second modulus is really chosen.
- A mode input toggled every few clocks. This tells a design that keeps its phase across a switch apart from one that clears or delays it.
- Repeated resets in both modes. These pin down the exact clock of the first pulse and the sample marker that comes with it.

// File: rtl/audio_clk_en_pkg.sv
package audio_clk_en_pkg;

  localparam int unsigned STEP_DEF  = 32'd1025280;
  localparam int unsigned MOD0_DEF  = 32'd21437280;
  localparam int unsigned MOD1_DEF  = 32'd21268800;
  localparam int unsigned SDIV_DEF  = 32;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int unsigned STEP  = audio_clk_en_pkg::STEP_DEF,
  parameter int unsigned MOD0  = audio_clk_en_pkg::MOD0_DEF,
  parameter int unsigned MOD1  = audio_clk_en_pkg::MOD1_DEF,
  parameter int unsigned ACC_W = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  output logic fire_o,
  output logic en_o
);

  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] MOD0_V = ACC_W'(MOD0);
  localparam logic [ACC_W-1:0] MOD1_V = ACC_W'(MOD1);
  localparam logic [ACC_W-1:0] MODMAX = ACC_W'(audio_clk_en_pkg::max_u(MOD0, MOD1));

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_d;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] modv;
  logic             en_q;

  always_comb begin
    modv    = mode_i ? MOD1_V : MOD0_V;
    sum     = phase_q + STEP_V;
    fire_o  = (sum >= modv);
    phase_d = fire_o ? (sum - modv) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      en_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      en_q    <= fire_o;
    end
  end

  assign en_o = en_q;

  // R7
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q < MODMAX);

  // R4
  en_gap_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> !en_q);

endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned DIV = audio_clk_en_pkg::SDIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= fire_i && (cnt_q == '0);
      if (fire_i) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> $stable(cnt_q));

  // R6
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (cnt_q != '0 || DIV == 1));

endmodule

// File: rtl/audio_clk_en_gen.sv
module audio_clk_en_gen #(
  parameter int unsigned STEP = audio_clk_en_pkg::STEP_DEF,
  parameter int unsigned MOD0 = audio_clk_en_pkg::MOD0_DEF,
  parameter int unsigned MOD1 = audio_clk_en_pkg::MOD1_DEF,
  parameter int unsigned SDIV = audio_clk_en_pkg::SDIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  output logic aud_en,
  output logic smp_en
);

  localparam int unsigned ACC_W = $clog2(audio_clk_en_pkg::max_u(MOD0, MOD1) + STEP) + 1;

  logic fire;

  phase_accum #(
    .STEP (STEP),
    .MOD0 (MOD0),
    .MOD1 (MOD1),
    .ACC_W(ACC_W)
  ) u_acc (
    .clk   (clk),
    .rst   (rst),
    .mode_i(mode_sel),
    .fire_o(fire),
    .en_o  (aud_en)
  );

  tick_div #(
    .DIV(SDIV)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .fire_i(fire),
    .tick_o(smp_en)
  );

  // R5
  smp_in_aud_chk: assert property (@(posedge clk) disable iff (rst)
    smp_en |-> aud_en);

  // R8
  aud_reg_chk: assert property (@(posedge clk) disable iff (rst)
    aud_en |-> $past(fire));

endmodule

// File: tb/audio_clk_en_gen_tb.sv
module audio_clk_en_gen_tb;

  localparam longint unsigned STEP = 1025280;
  localparam longint unsigned MOD0 = 21437280;
  localparam longint unsigned MOD1 = 21268800;

  typedef struct packed {
    logic rst;
    logic en;
    logic tick;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic aud_en, smp_en;

  always #2.5 clk = ~clk;

  audio_clk_en_gen u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .aud_en(aud_en), .smp_en(smp_en)
  );

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint unsigned m_acc = 0;
  int m_cnt = 0;

  int n_en = 0, n_tick = 0, since = 0, first_en = 0, first_tick = 0;
  int gap = 0;
  bit had_tick = 0;

  task automatic drive(input logic r, input logic m);
    item_t it;
    longint unsigned sum, md;
    @(negedge clk);
    rst = r;
    mode_sel = m;
    it.rst = r;
    if (r) begin
      m_acc = 0; m_cnt = 0; it.en = 0; it.tick = 0;
    end else begin
      md = m ? MOD1 : MOD0;
      sum = m_acc + STEP;
      it.en = (sum >= md);
      m_acc = it.en ? sum - md : sum;
      it.tick = it.en && (m_cnt == 0);
      if (it.en) m_cnt = (m_cnt + 1) % 32;
    end
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (aud_en !== e.en || smp_en !== e.tick) begin
        errors++;
        $display("FAIL R1/R2/R3/R7/R8 per-clock: actual en=%b tick=%b expected en=%b tick=%b",
                 aud_en, smp_en, e.en, e.tick);
      end
      if (e.rst) begin
        n_en = 0; n_tick = 0; since = 0; first_en = 0; first_tick = 0;
        gap = 0; had_tick = 0;
      end else begin
        since++;
        if (aud_en === 1'b1) begin
          n_en++; gap++;
          if (first_en == 0) first_en = since;
        end
        if (smp_en === 1'b1) begin
          n_tick++;
          if (first_tick == 0) first_tick = since;
          if (had_tick) begin
            checks++;
            if (gap != 33) begin
              errors++;
              $display("FAIL R6 sample spacing: actual %0d expected 32", gap - 1);
            end
          end
          had_tick = 1; gap = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic do_reset(input logic m);
    for (int i = 0; i < 3; i++) drive(1'b1, m);
  endtask

  task automatic run_mode(input logic m, input int n, input string req);
    longint unsigned md;
    longint unsigned exp_en;
    md = m ? MOD1 : MOD0;
    do_reset(m);
    for (int i = 0; i < n; i++) drive(1'b0, m);
    settle();
    exp_en = (longint'(n) * STEP) / md;
    check(n_en == exp_en, req, n_en, exp_en);
    check(n_tick == (exp_en + 31) / 32, {req, " R6 sample count"}, n_tick, (exp_en + 31) / 32);
    check(first_en == (md + STEP - 1) / STEP, "R1 first pulse", first_en, (md + STEP - 1) / STEP);
    check(first_tick == first_en, "R6 first sample", first_tick, first_en);
  endtask

  initial begin
    // R1: outputs while reset is held
    do_reset(1'b0);
    settle();
    check(aud_en === 1'b0 && smp_en === 1'b0, "R1 reset outputs", {aud_en, smp_en}, 0);

    run_mode(1'b0, 3000, "R2 mode0 count");
    run_mode(1'b1, 3000, "R3 mode1 count");

    // R7: toggle mode every 7 clocks without reset, per-clock compared
    do_reset(1'b0);
    for (int i = 0; i < 4000; i++) drive(1'b0, ((i / 7) % 2) == 1);
    settle();
    check(n_en > 0, "R7 pulses under toggling", n_en, 1);

    // R1: reset mid-run then restart
    for (int i = 0; i < 50; i++) drive(1'b0, 1'b1);
    run_mode(1'b1, 500, "R3 after mid reset");

    // R2/R4/R6: long drift run
    run_mode(1'b0, 60000, "R2 long run");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule